// File: doc/BRIEF.md
# Bit-Slice Data Routing Matrix

This block moves serial data from sixteen 8-bit source shift registers to sixteen 8-bit destination shift registers over a single shared bus bit. Two 8-way selector banks sit on the source side. A 3-bit channel address picks a channel inside a bank, and a fourth bit disables one bank so that only one source drives the bus. On the destination side, a latched 4-to-16 distributor steers the bus bit into the one addressed destination register. That register shifts the bit in, and every other destination holds.

An internal sequencer runs the selection sixteen times faster than the source registers shift. Every source gives up its current most significant bit before any source advances, so a run always takes 8 shift steps of 16 bus transfers each, 128 transfers in all. Pass mode routes source i to destination i and copies words unchanged. Slice mode sends the bits of one weight from the eight sources of a bank into one destination register, which transposes each bank as an 8x8 bit matrix.

Software-facing logic, if any, loads the sources through a write port and reads the destinations through a registered read port, then pulses `start`.

Top module: `slice_router`

## Requirements
- R1: After synchronous reset, all destination registers read 0, and `busy` and `done` are 0.
- R2: While `busy` is low, a cycle with `ld_en` high writes `ld_data` into the source register numbered `ld_idx`.
- R3: In pass mode (`mode_slice`=0), a run leaves destination i equal to the value loaded into source i, for every i.
- R4: In slice mode (`mode_slice`=1), with bank b = d/8 and k = d%8, destination d bit (7-j) equals bit (7-k) of source 8*b+j after a run.
- R5: A run ends with `done` rising on the 129th rising edge after the edge that samples `start` with `busy` low. `busy` is high from the edge after start until the edge on which `done` rises.
- R6: While `busy` is high, `ld_en` and `start` are ignored. A load does not alter the run's result, and a second start does not change the run length.
- R7: On each bus transfer at most one destination is enabled, and a destination register changes only on a cycle in which its own enable is set. The latched destination address holds while the strobe is low.
- R8: `rd_data` presents destination `rd_idx` one clock after `rd_idx` is applied.
- R9: `done` stays high after a run until the next accepted start, which clears it on the same edge.
- R10: Source registers shift MSB first and fill with zeros. A second run without reloading delivers all-zero destinations.
- R11: The routing mode is captured when start is accepted. Changing `mode_slice` during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Source register write enable |
| ld_idx | input | 4 | Source register number to write |
| ld_data | input | 8 | Word written to the source register |
| mode_slice | input | 1 | 0 = pass, 1 = slice; sampled at start |
| start | input | 1 | Begin a 128-transfer run |
| rd_idx | input | 4 | Destination register number to read |
| rd_data | output | 8 | Registered contents of destination `rd_idx` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run has finished |

## Verification
The in-RTL properties assume that `start` and `ld_en` are single-cycle pulses, and that `rst` is held for at least one clock before any stimulus. The properties on run length and on holding the destination latch also rely on the sequencer being the only driver of the strobe. The bench drives every input on the falling clock edge. It loads sources only between runs, except for the deliberate load and start pulses sent mid-run to test R6 and R11. For the transpose, the bench sweeps every single-bit source pattern across all 128 bit positions, and it computes each destination word from the index formulas in R3 and R4.

// File: rtl/slice_router_pkg.sv
package slice_router_pkg;

  typedef enum logic {
    ROUTE_PASS  = 1'b0,
    ROUTE_SLICE = 1'b1
  } route_mode_e;

endpackage

// File: rtl/sr_selector_bank.sv
// One 8-way source selector bank; a disabled bank drives 0 onto the wired-OR bus.
module sr_selector_bank #(
  parameter int CH = 8,
  localparam int CW = $clog2(CH)
) (
  input  logic          en,
  input  logic [CW-1:0] ch,
  input  logic [CH-1:0] msb_bits,
  output logic          bit_o
);

  assign bit_o = en & msb_bits[ch];

endmodule

// File: rtl/sr_distributor.sv
// Address latch plus one-of-N decoder steering the bus bit to a destination.
module sr_distributor #(
  parameter int N = 16,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [AW-1:0] dst_in,
  output logic [N-1:0]  en
);

  logic [AW-1:0] dst_q;
  logic          valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= strobe;
      if (strobe) dst_q <= dst_in;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign en[i] = valid_q && (dst_q == AW'(i));
  end

  p_one_dest_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(en));

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(dst_q));

endmodule

// File: rtl/sr_sequencer.sv
// Steps {shift step, source} through WORD_W*NSRC transfers and emits the address pair.
module sr_sequencer
  import slice_router_pkg::*;
#(
  parameter int NSRC    = 16,
  parameter int WORD_W  = 8,
  parameter int BANK_CH = 8,
  localparam int AW = $clog2(NSRC),
  localparam int SW = $clog2(WORD_W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode_in,
  output logic          strobe,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic          last
);

  logic        running;
  logic [SW-1:0] step;
  logic [AW-1:0] src_q;
  route_mode_e mode_q;

  assign strobe = running;
  assign src    = src_q;
  assign last   = (step == SW'(WORD_W - 1)) && (src_q == AW'(NSRC - 1));

  // Slice mode: the bank offset plus the step number picks the destination (requires WORD_W <= BANK_CH).
  always_comb begin
    if (mode_q == ROUTE_SLICE)
      dst = (src_q[AW-1] ? AW'(BANK_CH) : AW'(0)) + AW'(step);
    else
      dst = src_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      step    <= '0;
      src_q   <= '0;
      mode_q  <= ROUTE_PASS;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        step    <= '0;
        src_q   <= '0;
        mode_q  <= route_mode_e'(mode_in);
      end
    end else begin
      src_q <= src_q + 1'b1;
      if (last) begin
        running <= 1'b0;
        step    <= '0;
      end else if (src_q == AW'(NSRC - 1)) begin
        step <= step + 1'b1;
      end
    end
  end

  p_run_hold_r5: assert property (@(posedge clk) disable iff (rst)
    running && !last |=> running);

  p_run_end_r5: assert property (@(posedge clk) disable iff (rst)
    running && last |=> !running);

  p_seq_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !running && !start |=> !running);

endmodule

// File: rtl/slice_router.sv
module slice_router
  import slice_router_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int BANK_CH = 8,
  localparam int NSRC = 2 * BANK_CH,
  localparam int AW   = $clog2(NSRC),
  localparam int CW   = $clog2(BANK_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [AW-1:0]     ld_idx,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              mode_slice,
  input  logic              start,
  input  logic [AW-1:0]     rd_idx,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              done
);

  logic              strobe, seq_last, start_ok, ld_ok;
  logic [AW-1:0]     seq_src, seq_dst;
  logic [AW-1:0]     src_q;
  logic              xfer_q, last_q, done_q;
  logic [WORD_W-1:0] rd_q;
  logic [NSRC-1:0]   dist_en;
  logic [NSRC-1:0]   msb_vec;
  logic [1:0]        bank_bit;
  logic              bus;
  logic              shift_now;
  logic [WORD_W-1:0] in_q  [NSRC];
  logic [WORD_W-1:0] out_q [NSRC];

  assign busy     = strobe | xfer_q;
  assign start_ok = start & ~busy;
  assign ld_ok    = ld_en & ~busy;

  sr_sequencer #(.NSRC(NSRC), .WORD_W(WORD_W), .BANK_CH(BANK_CH)) u_seq (
    .clk(clk), .rst(rst), .start(start_ok), .mode_in(mode_slice),
    .strobe(strobe), .src(seq_src), .dst(seq_dst), .last(seq_last)
  );

  // Source address latch, captured on the same strobe as the destination.
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      xfer_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      xfer_q <= strobe;
      if (strobe) begin
        src_q  <= seq_src;
        last_q <= seq_last;
      end
    end
  end

  sr_distributor #(.N(NSRC)) u_dist (
    .clk(clk), .rst(rst), .strobe(strobe), .dst_in(seq_dst), .en(dist_en)
  );

  // Sources advance together once the last source of a step has been read.
  assign shift_now = xfer_q && (src_q == AW'(NSRC - 1));

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign msb_vec[i] = in_q[i][WORD_W-1];
    always_ff @(posedge clk) begin
      if (rst)
        in_q[i] <= '0;
      else if (ld_ok && ld_idx == AW'(i))
        in_q[i] <= ld_data;
      else if (shift_now)
        in_q[i] <= {in_q[i][WORD_W-2:0], 1'b0};
    end
  end

  // Bank select bit enables exactly one bank; bus is the OR of both.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    sr_selector_bank #(.CH(BANK_CH)) u_bank (
      .en(xfer_q && (src_q[AW-1] == 1'(b))),
      .ch(src_q[CW-1:0]),
      .msb_bits(msb_vec[b*BANK_CH +: BANK_CH]),
      .bit_o(bank_bit[b])
    );
  end
  assign bus = |bank_bit;

  for (genvar i = 0; i < NSRC; i++) begin : g_dst
    always_ff @(posedge clk) begin
      if (rst)
        out_q[i] <= '0;
      else if (dist_en[i])
        out_q[i] <= {out_q[i][WORD_W-2:0], bus};
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (out_q[i] != $past(out_q[i])) |-> $past(dist_en[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      rd_q <= out_q[rd_idx];
      if (start_ok)
        done_q <= 1'b0;
      else if (xfer_q && last_q)
        done_q <= 1'b1;
    end
  end

  assign rd_data = rd_q;
  assign done    = done_q;

  p_done_clear_r9: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> !done);

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done);

endmodule

// File: tb/sim_slice_router.sv
module sim_slice_router;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_en = 1'b0;
  logic [3:0] ld_idx = '0;
  logic [7:0] ld_data = '0;
  logic       mode_slice = 1'b0;
  logic       start = 1'b0;
  logic [3:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic       busy, done;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;
  logic [7:0] mdl [16];

  always #2.5 clk = ~clk;

  slice_router u0 (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .mode_slice(mode_slice), .start(start), .rd_idx(rd_idx),
    .rd_data(rd_data), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic load(input int idx, input logic [7:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 4'(idx); ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
    mdl[idx] = val;
  endtask

  task automatic read_out(input int idx, output logic [7:0] val);
    @(negedge clk);
    rd_idx = 4'(idx);
    @(negedge clk);
    val = rd_data;
  endtask

  // disturb: mid-run load, start and mode change, all of which must be ignored (R6, R11)
  task automatic run(input logic slice, input bit disturb, output int ncyc);
    @(negedge clk);
    mode_slice = slice; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R5 busy after start", busy, 1);
    chk(done === 1'b0, "R9 done cleared by start", done, 0);
    ncyc = 0;
    while (done !== 1'b1 && ncyc < 1000) begin
      @(negedge clk);
      ncyc++;
      if (disturb) begin
        if (ncyc == 5)  mode_slice = ~slice;
        if (ncyc == 10) begin ld_en = 1'b1; ld_idx = 4'd3; ld_data = ~mdl[3]; end
        if (ncyc == 11) ld_en = 1'b0;
        if (ncyc == 20) start = 1'b1;
        if (ncyc == 21) start = 1'b0;
      end
    end
    chk(busy === 1'b0, "R5 busy low at done", busy, 0);
  endtask

  function automatic logic [7:0] exp_out(input bit slice, input int d);
    logic [7:0] r;
    int b, k;
    if (!slice) return mdl[d];
    b = d / 8; k = d % 8;
    for (int j = 0; j < 8; j++) r[7-j] = mdl[b*8+j][7-k];
    return r;
  endfunction

  task automatic check_all(input bit slice, input bit zero, input string req);
    logic [7:0] v, e;
    for (int d = 0; d < 16; d++) begin
      read_out(d, v);
      e = zero ? 8'h00 : exp_out(slice, d);
      chk(v === e, req, v, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int n;
    logic [7:0] v;
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state; R8 read port
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(done === 1'b0, "R1 done", done, 0);
    for (int d = 0; d < 16; d++) begin
      read_out(d, v);
      chk(v === 8'h00, "R1 R8 reset out", v, 0);
    end

    // R2, R3 pass mode with two patterns; R5 length
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 16; i++) load(i, 8'((i * 37 + p * 91 + 5) ^ (p ? 8'h5A : 8'h00)));
      run(1'b0, 1'b0, n);
      chk(n == 129, "R5 run length", n, 129);
      check_all(1'b0, 1'b0, "R2 R3 pass copy");
    end

    // R9 done holds
    repeat (5) @(negedge clk);
    chk(done === 1'b1, "R9 done sticky", done, 1);

    // R10 second run without reload gives zeros
    run(1'b0, 1'b0, n);
    check_all(1'b0, 1'b1, "R10 drained sources");

    // R4 slice with patterned data, R6 R11 disturbed run
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 16; i++) load(i, 8'(i * 29 + p * 113 + 7));
      run(1'b1, p == 2, n);
      chk(n == 129, "R6 R5 run length", n, 129);
      check_all(1'b1, 1'b0, (p == 2) ? "R6 R11 ignored during run" : "R4 slice transpose");
    end

    // R6, R11 pass run with disturbance
    for (int i = 0; i < 16; i++) load(i, 8'(255 - i * 13));
    run(1'b0, 1'b1, n);
    chk(n == 129, "R6 second start ignored", n, 129);
    check_all(1'b0, 1'b0, "R6 R11 pass ignored during run");

    // R4 R7 exhaustive single-bit sweep over every source bit
    for (int s = 0; s < 16; s++) begin
      for (int b = 0; b < 8; b++) begin
        for (int i = 0; i < 16; i++) load(i, (i == s) ? 8'(1 << b) : 8'h00);
        run(1'b1, 1'b0, n);
        check_all(1'b1, 1'b0, "R4 R7 single-bit sweep");
      end
    end

    finish_run();
  end

endmodule